// File: doc/BRIEF.md
# LCD Timing Clock Selector-Divider

This block makes the timing tick for an LCD controller. Two oscillators reach it as single-cycle enable strobes in the system clock domain: a fast one and a slow one. A small configuration register picks which strobe to follow and how far to divide it. The block counts the chosen strobes and gives a one-cycle tick each time a full division period is complete.

Software sets the register through a simple one-cycle read/write port. The register has an enable bit, a two-bit source code and a two-bit ratio code. The fast source can be divided by one of four powers of two. The slow source is always divided by 64, whatever the ratio code holds. A status output shows whether the source code in the register names a real oscillator.

Top module: `lcd_tick_gen`

## Requirements
- R1: Register bit 0 is the enable. While it is 0, `tickOut` stays low and the divider count is held at zero.
- R2: Register bits 3:2 pick the source. Code 0 follows `fastStrobe` only and code 1 follows `slowStrobe` only. Strobes of the other input do not advance the count.
- R3: With source code 0, bits 5:4 set the period in fast strobes: code 0 gives 1024, code 1 gives 2048, code 2 gives 4096 and code 3 gives 8192.
- R4: With source code 1, the period is 64 slow strobes for every value of bits 5:4.
- R5: Bits 7:6 and bit 1 read back as 0, and writing 1 to them has no effect on the other fields or on the tick.
- R6: After reset the register reads 0x00.
- R7: Source codes 2 and 3 are reserved. With either code, `srcValid` is low and no tick is produced. With code 0 or 1, `srcValid` is high. `srcValid` follows the register in the cycle after the write edge.
- R8: A tick is one cycle wide. It is high in the cycle after the clock edge that takes the N-th counted strobe, where N is the period. The next tick follows after exactly N more counted strobes.
- R9: A write that changes the source or ratio field, or that clears the enable, restarts the count from zero. The strobe present at that write edge is not counted. A write that changes none of these lets the count run on.
- R10: A read request (`busEn` high, `busWr` low) places the register on `busRdata` after the next clock edge. `busRdata` holds that value until the next read. Reads do not change the register or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastStrobe | input | 1 | One-cycle strobe of the fast oscillator |
| slowStrobe | input | 1 | One-cycle strobe of the slow oscillator |
| busEn | input | 1 | Bus access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| tickOut | output | 1 | One-cycle divided tick |
| srcValid | output | 1 | Selected source code is 0 or 1 |

## Verification
The assertions assume that every division period is at least two counted strobes long. That assumption is what makes a tick always followed by a low cycle. The default parameters give periods of 64 or more. The assertions also assume that bus requests last a single cycle. The bench keeps `busEn` high for exactly one cycle per access and drives it only at falling edges. Strobes are held high on every cycle, so each period can be measured in clock cycles. They are lowered one input at a time to show that the unselected oscillator has no effect.

// File: rtl/lcd_tick_pkg.sv
package lcd_tick_pkg;

  localparam int REG_W     = 8;
  localparam int RATIO_W   = 2;
  localparam int EN_BIT    = 0;
  localparam int SRC_LSB   = 2;
  localparam int RATIO_LSB = 4;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_RSV2 = 2'd2,
    SRC_RSV3 = 2'd3
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               clearCnt;
    logic               step;
    logic               armed;
    logic               slowSrc;
    logic [RATIO_W-1:0] ratio;
  } divCtl_t;

endpackage

// File: rtl/lcd_tick_ctrl.sv
module lcd_tick_ctrl
  import lcd_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastStrobe,
  input  logic             slowStrobe,
  input  logic             busEn,
  input  logic             busWr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             srcValid,
  output divCtl_t          ctl
);

  logic               enableQ;
  srcSel_e            srcQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [REG_W-1:0]   rdataQ;

  logic               wrReq, rdReq;
  logic               newEnable;
  srcSel_e            newSrc;
  logic [RATIO_W-1:0] newRatio;
  logic               cfgChange;
  logic               srcOk;
  logic               selStrobe;
  logic [REG_W-1:0]   regView;
  logic               unusedWrBits;

  assign wrReq     = busEn && busWr;
  assign rdReq     = busEn && !busWr;
  assign newEnable = busWdata[EN_BIT];
  assign newSrc    = srcSel_e'(busWdata[SRC_LSB +: 2]);
  assign newRatio  = busWdata[RATIO_LSB +: RATIO_W];
  assign unusedWrBits = ^{busWdata[REG_W-1:RATIO_LSB+RATIO_W], busWdata[1]};

  assign cfgChange = wrReq && ((newSrc != srcQ) || (newRatio != ratioQ) ||
                               (enableQ && !newEnable));

  assign srcOk = (srcQ == SRC_FAST) || (srcQ == SRC_SLOW);

  always_comb begin
    case (srcQ)
      SRC_FAST: selStrobe = fastStrobe;
      SRC_SLOW: selStrobe = slowStrobe;
      default:  selStrobe = 1'b0;
    endcase
  end

  always_comb begin
    regView = '0;
    regView[EN_BIT]                = enableQ;
    regView[SRC_LSB +: 2]          = srcQ;
    regView[RATIO_LSB +: RATIO_W]  = ratioQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      srcQ    <= SRC_FAST;
      ratioQ  <= '0;
    end else if (wrReq) begin
      enableQ <= newEnable;
      srcQ    <= newSrc;
      ratioQ  <= newRatio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdataQ <= '0;
    else if (rdReq) rdataQ <= regView;
  end

  assign busRdata = rdataQ;
  assign srcValid = srcOk;

  assign ctl.armed    = enableQ && srcOk;
  assign ctl.clearCnt = cfgChange || !enableQ;
  assign ctl.step     = enableQ && srcOk && selStrobe && !cfgChange;
  assign ctl.slowSrc  = (srcQ == SRC_SLOW);
  assign ctl.ratio    = ratioQ;

  // R10
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq |=> $stable(regView)));

endmodule

// File: rtl/lcd_tick_div.sv
module lcd_tick_div
  import lcd_tick_pkg::*;
#(
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    tickOut
);

  localparam int NUM_RATIOS = 1 << RATIO_W;
  localparam int CNT_W      = FAST_LOG2 + NUM_RATIOS - 1;
  localparam int LIM_W      = CNT_W + 1;

  logic [LIM_W-1:0] fastLimit [NUM_RATIOS];
  logic [LIM_W-1:0] slowLimit;
  logic [LIM_W-1:0] curLimit;
  logic [CNT_W-1:0] cnt;
  logic             tickQ;
  logic             advance;
  logic             lastCount;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : gRatio
    assign fastLimit[g] = LIM_W'(1) << (FAST_LOG2 + g);
  end

  assign slowLimit = LIM_W'(1) << SLOW_LOG2;
  assign curLimit  = ctl.slowSrc ? slowLimit : fastLimit[ctl.ratio];
  assign advance   = ctl.step && ctl.armed;
  assign lastCount = ({1'b0, cnt} == (curLimit - LIM_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= 1'b0;
      if (ctl.clearCnt) begin
        cnt <= '0;
      end else if (advance) begin
        if (lastCount) begin
          cnt   <= '0;
          tickQ <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign tickOut = tickQ;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, cnt} < curLimit));

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut |=> !tickOut));

  // R1
  tick_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.armed |=> !tickOut));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearCnt |=> (cnt == '0)));

endmodule

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen
  import lcd_tick_pkg::*;
#(
  parameter int FAST_LOG2 = 10,
  parameter int SLOW_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fastStrobe,
  input  logic       slowStrobe,
  input  logic       busEn,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       tickOut,
  output logic       srcValid
);

  divCtl_t divCtl;

  lcd_tick_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fastStrobe (fastStrobe),
    .slowStrobe (slowStrobe),
    .busEn      (busEn),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .srcValid   (srcValid),
    .ctl        (divCtl)
  );

  lcd_tick_div #(
    .FAST_LOG2 (FAST_LOG2),
    .SLOW_LOG2 (SLOW_LOG2)
  ) uDiv (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (divCtl),
    .tickOut (tickOut)
  );

  // R7
  rsv_src_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcValid |=> !tickOut));

endmodule

// File: tb/lcd_tick_gen_test.sv
module lcd_tick_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 8;
  localparam logic [7:0] VEC_CFG [VEC_N] =
    '{8'h01, 8'h11, 8'h21, 8'h31, 8'h05, 8'h15, 8'h25, 8'h35};
  localparam int VEC_PER [VEC_N] =
    '{1024, 2048, 4096, 8192, 64, 64, 64, 64};

  logic       clk = 1'b0;
  logic       rstN;
  logic       fastStrobe, slowStrobe;
  logic       busEn, busWr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       tickOut, srcValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  lcd_tick_gen uut (
    .clk(clk), .rstN(rstN), .fastStrobe(fastStrobe), .slowStrobe(slowStrobe),
    .busEn(busEn), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .tickOut(tickOut), .srcValid(srcValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    busEn = 1'b1; busWr = 1'b1; busWdata = v;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic readReg(output logic [7:0] v);
    busEn = 1'b1; busWr = 1'b0;
    @(negedge clk);
    v = busRdata;
    busEn = 1'b0;
  endtask

  // Returns the cycle count until tickOut is seen, 0 if none
  task automatic waitTick(input int maxCyc, output int k);
    k = 0;
    for (int i = 1; i <= maxCyc; i++) begin
      @(negedge clk);
      if (tickOut) begin
        k = i;
        return;
      end
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    int k;
    rstN = 1'b0; fastStrobe = 1'b1; slowStrobe = 1'b1;
    busEn = 1'b0; busWr = 1'b0; busWdata = '0;
    repeat (3) @(negedge clk);
    check(tickOut == 1'b0, "R1 reset tick", tickOut, 0);
    check(srcValid == 1'b1, "R7 reset srcValid", srcValid, 1);
    rstN = 1'b1;
    @(negedge clk);
    readReg(rd);
    check(rd == 8'h00, "R6 reset readback", rd, 0);

    // Vector table: period, second period, status, readback
    for (int i = 0; i < VEC_N; i++) begin
      writeReg(8'h00);
      writeReg(VEC_CFG[i]);
      waitTick(VEC_PER[i] + 8, k);
      check(k == VEC_PER[i], (i < 4) ? "R3 first period" : "R4 first period", k, VEC_PER[i]);
      waitTick(VEC_PER[i] + 8, k);
      check(k == VEC_PER[i], "R8 second period", k, VEC_PER[i]);
      check(srcValid == 1'b1, "R7 valid source", srcValid, 1);
      readReg(rd);
      check(rd == VEC_CFG[i], "R10 readback", rd, VEC_CFG[i]);
    end

    // R1: disabled, no ticks
    writeReg(8'h30);
    waitTick(2000, k);
    check(k == 0, "R1 disabled no tick", k, 0);

    // R5 + R10: reserved bits ignored, reads leave count running
    writeReg(8'h00);
    writeReg(8'hC3);
    readReg(rd);
    check(rd == 8'h01, "R5 reserved bits read 0", rd, 8'h01);
    waitTick(1100, k);
    check(k == 1023, "R10 read no side effect", k, 1023);

    // R7: reserved source codes
    writeReg(8'hFF);
    check(srcValid == 1'b0, "R7 code 3 srcValid", srcValid, 0);
    readReg(rd);
    check(rd == 8'h3D, "R5 readback of 0xFF", rd, 8'h3D);
    waitTick(300, k);
    check(k == 0, "R7 code 3 no tick", k, 0);
    writeReg(8'h09);
    check(srcValid == 1'b0, "R7 code 2 srcValid", srcValid, 0);
    waitTick(300, k);
    check(k == 0, "R7 code 2 no tick", k, 0);

    // R2: only selected strobe counts
    fastStrobe = 1'b1; slowStrobe = 1'b0;
    writeReg(8'h05);
    waitTick(300, k);
    check(k == 0, "R2 slow selected, fast ignored", k, 0);
    fastStrobe = 1'b0; slowStrobe = 1'b1;
    writeReg(8'h01);
    waitTick(1100, k);
    check(k == 0, "R2 fast selected, slow ignored", k, 0);
    fastStrobe = 1'b1; slowStrobe = 1'b1;

    // R9: ratio change mid-period restarts count
    writeReg(8'h00);
    writeReg(8'h01);
    repeat (500) @(negedge clk);
    writeReg(8'h11);
    waitTick(2100, k);
    check(k == 2048, "R9 ratio change restart", k, 2048);

    // R9: disable then enable restarts
    writeReg(8'h00);
    writeReg(8'h01);
    repeat (500) @(negedge clk);
    writeReg(8'h00);
    writeReg(8'h01);
    waitTick(1100, k);
    check(k == 1024, "R9 disable restart", k, 1024);

    // R9: unchanged write keeps count
    writeReg(8'h00);
    writeReg(8'h01);
    repeat (500) @(negedge clk);
    writeReg(8'h01);
    waitTick(1100, k);
    check(k == 523, "R9 same-value write keeps count", k, 523);

    // R9: source change restarts with new period
    writeReg(8'h00);
    writeReg(8'h01);
    repeat (500) @(negedge clk);
    writeReg(8'h05);
    waitTick(200, k);
    check(k == 64, "R9 source change restart", k, 64);

    finishRun();
  end

endmodule